// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register of recent branch outcomes, called the global history. It also keeps a table of small saturating counters. A table entry is chosen from a slice of the branch address combined with the global history. The combination is either a concatenation of the two or an XOR hash of the two, and an elaboration parameter selects which. The lookup port is purely combinational. Given a fetch address, it returns the direction guess in the same cycle, together with the current history. The front end carries that history along with the branch.

When the branch resolves, the update port receives the branch address, the real outcome and the history that was captured at lookup. It trains the one counter that this pair selects. In the same clock edge, the real outcome is shifted into the global history. Repairing the history after a misprediction is the caller's job.

Top module: `bp_corr_predictor`

## Requirements
- R1: On each clock edge with `upd_valid` high, the history register shifts left by one and takes `upd_taken` into bit 0 (1 = taken). Without `upd_valid` it holds. `look_hist` always shows the register.
- R2: In concatenation mode the table index is {pc[ADDR_W+1:2], history}, with the history in the low bits.
- R3: In hash mode the table index is pc[ADDR_W+HIST_W+1:2] XOR the history zero-extended to ADDR_W+HIST_W bits.
- R4: `look_taken` is 1 exactly when the counter selected by `look_pc` and the current history is at least 2^(CTR_W-1). It is valid in the same cycle as `look_pc`.
- R5: An update moves the selected counter up by one on taken and down by one on not taken. The counter stays within 0 to 2^CTR_W-1.
- R6: Only the counter selected by `upd_pc` and `upd_hist` changes. No counter changes while `upd_valid` is low.
- R7: Synchronous reset sets every counter to 2^(CTR_W-1)-1 (weakly not taken) and clears the history.
- R8: Bits 1:0 of both address inputs have no effect.
- R9: A lookup in the same cycle as an update to the same entry sees the value from before the update. The new value and the new history are visible from the next cycle on.
- R10: With 2-bit counters, a counter in a strong state reverses its guess only after two consecutive opposite outcomes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| look_pc | input | PC_W | Address of the branch being looked up |
| look_taken | output | 1 | Direction guess, 1 = taken |
| look_hist | output | HIST_W | Global history used for this lookup |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| upd_hist | input | HIST_W | History captured when the branch was looked up |

## Verification
Lookup results are combinational. The bench therefore drives `look_pc` and the update fields just after a falling edge and samples `look_taken` and `look_hist` 1 ns later, in that same cycle. An update takes effect at the next rising edge. The bench folds each update into its reference table and history only after that cycle's lookup has been checked, so the next cycle's lookup is compared against the trained state. This also exercises the same-cycle read-before-write behaviour. Two instances, one in each index mode, see identical stimulus and are checked against separate reference tables.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // How address bits and history bits are combined into a table index.
    typedef enum logic {
        IDX_CONCAT = 1'b0,
        IDX_XOR    = 1'b1
    } bp_idx_mode_e;

    // Lowest address bit that takes part in indexing (word-aligned code).
    localparam int unsigned PC_LSB = 2;

endpackage

// File: rtl/bp_ghr.sv
module bp_ghr #(
    parameter int unsigned HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist_q
);

    logic [HIST_W-1:0] hist_d;

    generate
        if (HIST_W > 1) begin : g_wide
            assign hist_d = {hist_q[HIST_W-2:0], shift_bit};
        end else begin : g_one
            assign hist_d = shift_bit;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            hist_q <= '0;
        else if (shift_en)
            hist_q <= hist_d;
    end

    // R1: newest outcome lands in bit 0
    p_newest_lsb_r1: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> hist_q[0] == $past(shift_bit));

    // R1: history holds when no branch resolves
    p_hold_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/bp_index.sv
module bp_index #(
    parameter int unsigned          PC_W   = 32,
    parameter int unsigned          ADDR_W = 4,
    parameter int unsigned          HIST_W = 2,
    parameter bp_pkg::bp_idx_mode_e MODE   = bp_pkg::IDX_CONCAT,
    localparam int unsigned         IDX_W  = ADDR_W + HIST_W
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    generate
        if (MODE == bp_pkg::IDX_XOR) begin : g_hash
            // R3: fold the history into the low address bits
            assign idx = pc[bp_pkg::PC_LSB +: IDX_W] ^ {{ADDR_W{1'b0}}, hist};
        end else begin : g_cat
            // R2: address row on top, history column below
            assign idx = {pc[bp_pkg::PC_LSB +: ADDR_W], hist};
        end
    endgenerate

endmodule

// File: rtl/bp_pht.sv
module bp_pht #(
    parameter int unsigned  IDX_W   = 6,
    parameter int unsigned  CTR_W   = 2,
    localparam int unsigned ENTRIES = 1 << IDX_W,
    localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}},
    localparam logic [CTR_W-1:0] CTR_WNT = {1'b0, {(CTR_W-1){1'b1}}}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    logic [ENTRIES-1:0][CTR_W-1:0] tbl;
    logic [CTR_W-1:0]              wr_cur;
    logic [CTR_W-1:0]              wr_next;

    assign rd_ctr = tbl[rd_idx];
    assign wr_cur = tbl[wr_idx];

    always_comb begin
        wr_next = wr_cur;
        if (wr_taken && wr_cur != CTR_MAX)
            wr_next = wr_cur + 1'b1;
        else if (!wr_taken && wr_cur != '0)
            wr_next = wr_cur - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++)
                tbl[i] <= CTR_WNT;
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_next;
        end
    end

    // R5: clamp at the top
    p_sat_top_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_taken && tbl[wr_idx] == CTR_MAX |=> tbl[$past(wr_idx)] == CTR_MAX);

    // R5: clamp at the bottom
    p_sat_bot_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_taken && tbl[wr_idx] == '0 |=> tbl[$past(wr_idx)] == '0);

    // R5: single step upward below the top
    p_step_up_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_taken && tbl[wr_idx] != CTR_MAX
        |=> tbl[$past(wr_idx)] == CTR_W'($past(tbl[wr_idx]) + 1'b1));

    // R6: nothing in the table moves without an update
    p_idle_table_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(tbl));

endmodule

// File: rtl/bp_corr_predictor.sv
module bp_corr_predictor #(
    parameter int unsigned          PC_W     = 32,
    parameter int unsigned          HIST_W   = 2,
    parameter int unsigned          ADDR_W   = 4,
    parameter int unsigned          CTR_W    = 2,
    parameter bp_pkg::bp_idx_mode_e IDX_MODE = bp_pkg::IDX_CONCAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   look_pc,
    output logic              look_taken,
    output logic [HIST_W-1:0] look_hist,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] upd_hist
);

    localparam int unsigned IDX_W = ADDR_W + HIST_W;

    logic [HIST_W-1:0] ghr;
    logic [IDX_W-1:0]  look_idx;
    logic [IDX_W-1:0]  upd_idx;
    logic [CTR_W-1:0]  look_ctr;

    bp_ghr #(.HIST_W(HIST_W)) u_ghr (
        .clk(clk), .rst(rst),
        .shift_en(upd_valid), .shift_bit(upd_taken),
        .hist_q(ghr)
    );

    bp_index #(.PC_W(PC_W), .ADDR_W(ADDR_W), .HIST_W(HIST_W), .MODE(IDX_MODE)) u_look_idx (
        .pc(look_pc), .hist(ghr), .idx(look_idx)
    );

    bp_index #(.PC_W(PC_W), .ADDR_W(ADDR_W), .HIST_W(HIST_W), .MODE(IDX_MODE)) u_upd_idx (
        .pc(upd_pc), .hist(upd_hist), .idx(upd_idx)
    );

    bp_pht #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_pht (
        .clk(clk), .rst(rst),
        .rd_idx(look_idx), .rd_ctr(look_ctr),
        .wr_en(upd_valid), .wr_idx(upd_idx), .wr_taken(upd_taken)
    );

    // R4: the counter's top bit carries the direction
    assign look_taken = look_ctr[CTR_W-1];
    assign look_hist  = ghr;

    // R9: a lookup with no update and unchanged inputs keeps its answer
    p_quiet_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !upd_valid && $stable(look_pc) |=> $stable(look_taken) || !$stable(look_pc));

endmodule

// File: tb/bp_corr_predictor_tb.sv
module bp_corr_predictor_tb;

    localparam int PC_W = 32;
    localparam int K    = 2;
    localparam int M    = 4;
    localparam int N    = 2;
    localparam int NENT = 1 << (M + K);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] look_pc = '0;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic [K-1:0]    upd_hist = '0;
    logic            pred_c, pred_x;
    logic [K-1:0]    hist_c, hist_x;

    int n_checks = 0;
    int n_errors = 0;

    int           ref_c [NENT];
    int           ref_x [NENT];
    logic [K-1:0] ref_hist;

    always #10 clk = ~clk;

    bp_corr_predictor #(.PC_W(PC_W), .HIST_W(K), .ADDR_W(M), .CTR_W(N),
                        .IDX_MODE(bp_pkg::IDX_CONCAT)) u_dut (
        .clk(clk), .rst(rst), .look_pc(look_pc), .look_taken(pred_c), .look_hist(hist_c),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_hist(upd_hist)
    );

    bp_corr_predictor #(.PC_W(PC_W), .HIST_W(K), .ADDR_W(M), .CTR_W(N),
                        .IDX_MODE(bp_pkg::IDX_XOR)) u_dut_gs (
        .clk(clk), .rst(rst), .look_pc(look_pc), .look_taken(pred_x), .look_hist(hist_x),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_hist(upd_hist)
    );

    function automatic int idx_cat(logic [PC_W-1:0] pc, logic [K-1:0] h);
        int a;
        a = int'((pc >> 2) & ((1 << M) - 1));
        return a * (1 << K) + int'(h);
    endfunction

    function automatic int idx_hash(logic [PC_W-1:0] pc, logic [K-1:0] h);
        int a;
        a = int'((pc >> 2) & ((1 << (M + K)) - 1));
        return a ^ int'(h);
    endfunction

    function automatic int sat_step(int v, logic t);
        if (t) return (v < (1 << N) - 1) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic reset_ref();
        for (int i = 0; i < NENT; i++) begin
            ref_c[i] = (1 << (N - 1)) - 1;
            ref_x[i] = (1 << (N - 1)) - 1;
        end
        ref_hist = '0;
    endtask

    // One cycle: drive after negedge, check lookup, then apply the update at posedge.
    task automatic step(logic [PC_W-1:0] lpc, logic uv, logic [PC_W-1:0] upc,
                        logic ut, logic [K-1:0] uh, string tag);
        look_pc   = lpc;
        upd_valid = uv;
        upd_pc    = upc;
        upd_taken = ut;
        upd_hist  = uh;
        #1;
        check({tag, " R2 R4 concat guess"}, int'(pred_c),
              int'(ref_c[idx_cat(lpc, ref_hist)] >= (1 << (N - 1))));
        check({tag, " R3 R4 hash guess"}, int'(pred_x),
              int'(ref_x[idx_hash(lpc, ref_hist)] >= (1 << (N - 1))));
        check({tag, " R1 history"}, int'(hist_c), int'(ref_hist));
        check({tag, " R1 history hash inst"}, int'(hist_x), int'(ref_hist));
        if (uv) begin
            ref_c[idx_cat(upc, uh)]  = sat_step(ref_c[idx_cat(upc, uh)], ut);
            ref_x[idx_hash(upc, uh)] = sat_step(ref_x[idx_hash(upc, uh)], ut);
            ref_hist = {ref_hist[K-2:0], ut};
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : stim
        logic [PC_W-1:0] a;
        logic [K-1:0]    h;
        void'($urandom(32'd4242));
        reset_ref();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7: every entry weakly not taken, history empty
        for (int r = 0; r < (1 << M); r++) begin
            look_pc = PC_W'(r << 2);
            #1;
            check("R7 reset guess", int'(pred_c), 0);
            check("R7 reset guess hash", int'(pred_x), 0);
            check("R7 reset history", int'(hist_c), 0);
            @(negedge clk);
        end

        // R10 / R5: train one branch to strong taken, then two not-taken outcomes.
        a = 32'h0000_0040;
        for (int i = 0; i < 4; i++) step(a, 1'b1, a, 1'b1, 2'b00, "R5 saturate up");
        step(a, 1'b1, a, 1'b0, 2'b00, "R10 first miss");
        step(a, 1'b1, a, 1'b0, 2'b00, "R10 second miss");
        for (int i = 0; i < 4; i++) step(a, 1'b1, a, 1'b0, 2'b00, "R5 saturate down");

        // R9: lookup of the entry being updated in the same cycle
        step(a, 1'b1, a, 1'b1, ref_hist, "R9 same cycle");
        step(a, 1'b0, a, 1'b0, ref_hist, "R9 next cycle");

        // R8: low address bits vary on both ports
        for (int i = 0; i < 16; i++)
            step(a | PC_W'(i & 3), 1'b1, a | PC_W'((i >> 2) & 3), i[0], 2'b01, "R8 low bits");

        // R6: idle cycles leave table and history untouched
        for (int i = 0; i < 32; i++)
            step(PC_W'($urandom), 1'b0, PC_W'($urandom), 1'b1, 2'b11, "R6 idle");

        // Random mix, mostly updating with the history seen at lookup.
        for (int i = 0; i < 3000; i++) begin
            a = PC_W'($urandom_range(0, 255)) << 2;
            h = ($urandom_range(0, 3) == 0) ? K'($urandom) : ref_hist;
            step(PC_W'($urandom_range(0, 255)) << 2, ($urandom_range(0, 3) != 0),
                 a, $urandom_range(0, 1) == 1, h, "R6 random");
        end

        // R7: reset mid-run restores the initial state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        reset_ref();
        for (int r = 0; r < 8; r++)
            step(PC_W'(r << 2), 1'b0, '0, 1'b0, '0, "R7 re-reset");

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule